// File: doc/BRIEF.md
# DDR SDRAM Command Timing Controller

This block sits between a simple request port and the command pins of a four-bank DDR SDRAM. A client presents one request at a time: a read or write to a bank, row and column; a refresh; a mode-register load; or a power-down. The controller turns each request into the legal sequence of memory commands. It opens a row when the bank is closed. It closes a bank whose open row differs from the one asked for. It closes every bank before any command that needs an idle device. It holds every command until the spacing rules measured in memory-clock cycles allow it.

A free-running interval counter owes the device one auto-refresh for every interval that elapses. Owed refreshes are served ahead of client requests. While nothing legal can go out, the pins carry a NOP. A request is taken through a valid/ready handshake: ready rises in the same cycle in which the request's own column, refresh or mode command is chosen. That command appears on the pins one clock later.

For a mode-register load, `req_row` carries the opcode and `req_bank` selects which mode register is written. All limits are parameters expressed in clock cycles. The defaults match a 7.5 ns clock.

Top module: `ddrc_cmd_sched`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, CKE is high and the pins carry NOP. NOP is /CS,/RAS,/CAS,/WE = 0,1,1,1.
- R2: Command encodings on /CS,/RAS,/CAS,/WE are: activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, mode load 0000. BA carries the bank index 0..3. A read or write puts the column on A[9:0] with A10 low. A mode load puts the opcode on A[12:0] and the requested bank value on BA.
- R3: When a read (op 0) or write (op 1) is accepted, the next cycle carries the matching read or write command with the request's bank and column. At that moment, the row the controller last opened in that bank equals the request's row.
- R4: A read or write comes at least T_RCD=3 cycles after the activate of its bank. For a request to a closed bank with no other constraint pending, the gap is exactly 3 cycles.
- R5: A precharge of an open bank comes at least T_RAS=6 cycles after its activate, at least 2 cycles after its last read, and at least 5 cycles after its last write. The write figure is 1 + burst/2 + T_WR.
- R6: An activate targets a closed bank. It comes at least T_RP=3 cycles after that bank's last precharge and at least T_RC=9 cycles after that bank's last activate. It also comes at least T_RRD=2 cycles after any other activate.
- R7: Refresh, mode load and power-down entry happen only when every bank is closed. Any open banks are first closed by a precharge with A10 high. An accepted refresh request (op 2) puts a refresh command on the next cycle.
- R8: After a refresh, the pins carry NOP for T_RFC-1 = 9 cycles. After a mode load, the pins carry NOP for T_MRD-1 = 1 cycle.
- R9: Every T_REFI=1040 cycles, one refresh becomes owed. Up to 8 owed refreshes are remembered. An owed refresh is served before any waiting client request.
- R10: After a power-down request (op 4) is accepted, CKE is low from the next cycle. While CKE is low, and on the first cycle after it rises, the pins carry NOP. A waiting request or an owed refresh raises CKE.
- R11: A read or write to a bank open on a different row causes a precharge of that bank alone (A10 low). An activate of the new row follows.
- R12: Op codes 5, 6 and 7 are accepted. They leave the next cycle as NOP with CKE high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle |
| req_op | input | 3 | 0 read, 1 write, 2 refresh, 3 mode load, 4 power-down |
| req_bank | input | 2 | Target bank, or mode register select |
| req_row | input | 13 | Row address, or mode opcode |
| req_col | input | 10 | Column address |
| dram_cke | output | 1 | Clock enable |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_ba | output | 2 | Bank address |
| dram_a | output | 13 | Address bus |

## Verification
A stale open-bank flag shows at the pins on the very next command to that bank. It appears either as a read to a bank that is closed, or as a second activate to a bank that is already open. A per-bank timer that is off by one cycle lets a command out one cycle early, which breaks a minimum spacing at the moment it leaves. A broken power-down or mode-load path is seen one cycle after acceptance, in CKE or in the command code. A drifting refresh interval shows within about 1040 cycles, either as a late first refresh or as too few refreshes over a long run.

// File: rtl/ddrc_pkg.sv
`timescale 1ns/1ps
package ddrc_pkg;
    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } ddr_cmd_e;

    localparam logic [2:0] OP_READ    = 3'd0;
    localparam logic [2:0] OP_WRITE   = 3'd1;
    localparam logic [2:0] OP_REFRESH = 3'd2;
    localparam logic [2:0] OP_MODE    = 3'd3;
    localparam logic [2:0] OP_PDOWN   = 3'd4;
endpackage

// File: rtl/ddrc_bank_timer.sv
`timescale 1ns/1ps
module ddrc_bank_timer #(
    parameter int ROW_W = 13,
    parameter int T_RCD = 3,
    parameter int T_RAS = 6,
    parameter int T_RC  = 9,
    parameter int T_RP  = 3,
    parameter int T_RTP = 2,
    parameter int T_WTP = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             rd_i,
    input  logic             wr_i,
    input  logic             pre_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             rw_ok_o,
    output logic             pre_ok_o,
    output logic             act_ok_o
);
    localparam int CW = $clog2(T_RC + T_RAS + T_WTP + T_RP + 2);
    localparam logic [CW-1:0] L_RCD = CW'(T_RCD - 1);
    localparam logic [CW-1:0] L_RAS = CW'(T_RAS - 1);
    localparam logic [CW-1:0] L_RC  = CW'(T_RC - 1);
    localparam logic [CW-1:0] L_RP  = CW'(T_RP - 1);
    localparam logic [CW-1:0] L_RTP = CW'(T_RTP - 1);
    localparam logic [CW-1:0] L_WTP = CW'(T_WTP - 1);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [CW-1:0]    to_rw;   // cycles until column command allowed
        logic [CW-1:0]    to_pre;  // cycles until precharge allowed
        logic [CW-1:0]    to_act;  // cycles until activate allowed
    } bank_t;

    bank_t s_d, s_q;

    function automatic logic [CW-1:0] dec(input logic [CW-1:0] c);
        return (c != '0) ? c - 1'b1 : '0;
    endfunction

    function automatic logic [CW-1:0] bump(input logic [CW-1:0] c, input logic [CW-1:0] lim);
        return (c > lim) ? c : lim;
    endfunction

    always_comb begin
        s_d        = s_q;
        s_d.to_rw  = dec(s_q.to_rw);
        s_d.to_pre = dec(s_q.to_pre);
        s_d.to_act = dec(s_q.to_act);
        if (act_i) begin
            s_d.open   = 1'b1;
            s_d.row    = row_i;
            s_d.to_rw  = bump(s_d.to_rw, L_RCD);
            s_d.to_pre = bump(s_d.to_pre, L_RAS);
            s_d.to_act = bump(s_d.to_act, L_RC);
        end
        if (rd_i) s_d.to_pre = bump(s_d.to_pre, L_RTP);
        if (wr_i) s_d.to_pre = bump(s_d.to_pre, L_WTP);
        if (pre_i) begin
            s_d.open   = 1'b0;
            s_d.to_act = bump(s_d.to_act, L_RP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign open_o   = s_q.open;
    assign row_o    = s_q.row;
    assign rw_ok_o  = (s_q.to_rw == '0);
    assign pre_ok_o = (s_q.to_pre == '0);
    assign act_ok_o = (s_q.to_act == '0);
endmodule

// File: rtl/ddrc_refresh_tick.sv
`timescale 1ns/1ps
module ddrc_refresh_tick #(
    parameter int T_REFI   = 1040,
    parameter int MAX_OWED = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic served_i,
    output logic owed_o
);
    localparam int TW = $clog2(T_REFI);
    localparam int OW = $clog2(MAX_OWED + 1);

    typedef struct packed {
        logic [TW-1:0] tmr;
        logic [OW-1:0] owed;
    } tick_t;

    tick_t s_d, s_q;
    logic  wrap, inc, take;

    always_comb begin
        s_d     = s_q;
        wrap    = (s_q.tmr == TW'(T_REFI - 1));
        s_d.tmr = wrap ? '0 : s_q.tmr + 1'b1;
        inc     = wrap && (s_q.owed != OW'(MAX_OWED));
        take    = served_i && (s_q.owed != '0);
        if (inc && !take)      s_d.owed = s_q.owed + 1'b1;
        else if (!inc && take) s_d.owed = s_q.owed - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign owed_o = (s_q.owed != '0);
endmodule

// File: rtl/ddrc_cmd_sched.sv
`timescale 1ns/1ps
module ddrc_cmd_sched
    import ddrc_pkg::*;
#(
    parameter int BANKS     = 4,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int BURST_LEN = 4,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 6,
    parameter int T_RC      = 9,
    parameter int T_RRD     = 2,
    parameter int T_RFC     = 10,
    parameter int T_WR      = 2,
    parameter int T_MRD     = 2,
    parameter int T_REFI    = 1040,
    parameter int MAX_OWED  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [2:0]               req_op,
    input  logic [$clog2(BANKS)-1:0] req_bank,
    input  logic [ROW_W-1:0]         req_row,
    input  logic [COL_W-1:0]         req_col,
    output logic                     dram_cke,
    output logic                     dram_cs_n,
    output logic                     dram_ras_n,
    output logic                     dram_cas_n,
    output logic                     dram_we_n,
    output logic [$clog2(BANKS)-1:0] dram_ba,
    output logic [ROW_W-1:0]         dram_a
);
    localparam int BA_W   = $clog2(BANKS);
    localparam int T_RTP  = BURST_LEN / 2;
    localparam int T_WTP  = 1 + BURST_LEN / 2 + T_WR;
    localparam int GW     = $clog2(T_RFC + T_MRD + T_RRD + 1);
    localparam int AP_BIT = 10;

    typedef struct packed {
        ddr_cmd_e         cmd;
        logic             cke;
        logic [BA_W-1:0]  ba;
        logic [ROW_W-1:0] addr;
        logic             pd;
        logic [GW-1:0]    busy;
        logic [GW-1:0]    rrd;
    } sched_t;

    sched_t s_d, s_q;

    logic [BANKS-1:0]            act_v, rd_v, wr_v, pre_v;
    logic [BANKS-1:0]            open_w, rw_ok, pre_ok, act_ok;
    logic [BANKS-1:0][ROW_W-1:0] row_w;
    logic                        owed, served, need_idle, is_rw;

    for (genvar gb = 0; gb < BANKS; gb++) begin : g_bank
        ddrc_bank_timer #(
            .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC),
            .T_RP(T_RP), .T_RTP(T_RTP), .T_WTP(T_WTP)
        ) u_bank (
            .clk(clk), .rst_n(rst_n),
            .act_i(act_v[gb]), .rd_i(rd_v[gb]), .wr_i(wr_v[gb]), .pre_i(pre_v[gb]),
            .row_i(req_row),
            .open_o(open_w[gb]), .row_o(row_w[gb]),
            .rw_ok_o(rw_ok[gb]), .pre_ok_o(pre_ok[gb]), .act_ok_o(act_ok[gb])
        );
    end

    ddrc_refresh_tick #(.T_REFI(T_REFI), .MAX_OWED(MAX_OWED)) u_tick (
        .clk(clk), .rst_n(rst_n), .served_i(served), .owed_o(owed)
    );

    always_comb begin
        s_d       = s_q;
        s_d.cmd   = CMD_NOP;
        s_d.ba    = '0;
        s_d.addr  = '0;
        s_d.busy  = (s_q.busy != '0) ? s_q.busy - 1'b1 : '0;
        s_d.rrd   = (s_q.rrd != '0) ? s_q.rrd - 1'b1 : '0;
        act_v     = '0;
        rd_v      = '0;
        wr_v      = '0;
        pre_v     = '0;
        served    = 1'b0;
        req_ready = 1'b0;
        is_rw     = (req_op == OP_READ) || (req_op == OP_WRITE);
        need_idle = owed || (req_valid &&
                    (req_op == OP_REFRESH || req_op == OP_MODE || req_op == OP_PDOWN));

        if (s_q.pd) begin
            // leave power-down; the cycle with CKE raised carries NOP
            if (req_valid || owed) begin
                s_d.cke = 1'b1;
                s_d.pd  = 1'b0;
            end
        end else if (s_q.busy != '0) begin
            // refresh or mode-load recovery: NOP
        end else if (need_idle) begin
            if (|open_w) begin
                if (&pre_ok) begin
                    s_d.cmd          = CMD_PRE;
                    s_d.addr[AP_BIT] = 1'b1;
                    pre_v            = '1;
                end
            end else if (&act_ok) begin
                if (owed || req_op == OP_REFRESH) begin
                    s_d.cmd   = CMD_REF;
                    s_d.busy  = GW'(T_RFC - 1);
                    served    = owed;
                    req_ready = req_valid && (req_op == OP_REFRESH);
                end else if (req_op == OP_MODE) begin
                    s_d.cmd   = CMD_MRS;
                    s_d.ba    = req_bank;
                    s_d.addr  = req_row;
                    s_d.busy  = GW'(T_MRD - 1);
                    req_ready = 1'b1;
                end else begin
                    s_d.cke   = 1'b0;
                    s_d.pd    = 1'b1;
                    req_ready = 1'b1;
                end
            end
        end else if (req_valid) begin
            if (!is_rw) begin
                req_ready = 1'b1;
            end else if (open_w[req_bank]) begin
                if (row_w[req_bank] == req_row) begin
                    if (rw_ok[req_bank]) begin
                        s_d.cmd               = (req_op == OP_READ) ? CMD_RD : CMD_WR;
                        s_d.ba                = req_bank;
                        s_d.addr[COL_W-1:0]   = req_col;
                        rd_v[req_bank]        = (req_op == OP_READ);
                        wr_v[req_bank]        = (req_op == OP_WRITE);
                        req_ready             = 1'b1;
                    end
                end else if (pre_ok[req_bank]) begin
                    s_d.cmd         = CMD_PRE;
                    s_d.ba          = req_bank;
                    pre_v[req_bank] = 1'b1;
                end
            end else if (act_ok[req_bank] && s_q.rrd == '0) begin
                s_d.cmd         = CMD_ACT;
                s_d.ba          = req_bank;
                s_d.addr        = req_row;
                s_d.rrd         = GW'(T_RRD - 1);
                act_v[req_bank] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.cmd <= CMD_NOP;
            s_q.cke <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign dram_cke   = s_q.cke;
    assign dram_cs_n  = s_q.cmd[3];
    assign dram_ras_n = s_q.cmd[2];
    assign dram_cas_n = s_q.cmd[1];
    assign dram_we_n  = s_q.cmd[0];
    assign dram_ba    = s_q.ba;
    assign dram_a     = s_q.addr;
endmodule

// File: rtl/ddrc_cmd_sched_chk.sv
`timescale 1ns/1ps
module ddrc_cmd_sched_chk
    import ddrc_pkg::*;
#(
    parameter int BANKS = 4,
    parameter int COL_W = 10,
    parameter int T_RFC = 10
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic [2:0]               req_op,
    input logic [$clog2(BANKS)-1:0] req_bank,
    input logic [COL_W-1:0]         req_col,
    input logic                     dram_cke,
    input logic                     dram_cs_n,
    input logic                     dram_ras_n,
    input logic                     dram_cas_n,
    input logic                     dram_we_n,
    input logic [$clog2(BANKS)-1:0] dram_ba,
    input logic [12:0]              dram_a
);
    localparam int RW = $clog2(T_RFC + 1);

    logic [3:0]       cmd;
    logic [BANKS-1:0] open_q;
    logic [RW-1:0]    since_ref;
    logic             take;

    assign cmd  = {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n};
    assign take = req_valid && req_ready;

    // banks opened and closed as seen on the pins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q    <= '0;
            since_ref <= RW'(T_RFC);
        end else begin
            if (cmd == CMD_ACT) open_q[dram_ba] <= 1'b1;
            if (cmd == CMD_PRE) begin
                if (dram_a[10]) open_q <= '0;
                else            open_q[dram_ba] <= 1'b0;
            end
            if (cmd == CMD_REF)                 since_ref <= RW'(1);
            else if (since_ref != RW'(T_RFC))   since_ref <= since_ref + 1'b1;
        end
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dram_cke && cmd == CMD_NOP));

    p_col_a10_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD || cmd == CMD_WR) |-> !dram_a[10]);

    p_rw_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (req_op == OP_READ || req_op == OP_WRITE)) |=>
        ((cmd == CMD_RD || cmd == CMD_WR) && dram_ba == $past(req_bank) &&
         dram_a[COL_W-1:0] == $past(req_col)));

    p_idle_for_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF || cmd == CMD_MRS || $fell(dram_cke)) |-> (open_q == '0));

    p_ref_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |-> (since_ref >= RW'(T_RFC)));

    p_mrs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS) |=> (cmd == CMD_NOP));

    p_pd_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op == OP_PDOWN) |=> !dram_cke);

    p_pd_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cke || $rose(dram_cke)) |-> (cmd == CMD_NOP));

    p_unused_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op > OP_PDOWN) |=> (cmd == CMD_NOP && dram_cke));
endmodule

bind ddrc_cmd_sched ddrc_cmd_sched_chk #(
    .BANKS(BANKS), .COL_W(COL_W), .T_RFC(T_RFC)
) u_chk (.*);

// File: tb/ddrc_cmd_sched_tb_top.sv
`timescale 1ns/1ps
module ddrc_cmd_sched_tb_top;
    localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                           C_ACT = 4'b0011, C_WR  = 4'b0100, C_RD  = 4'b0101,
                           C_NOP = 4'b0111;
    localparam int E_RCD = 3, E_RP = 3, E_RAS = 6, E_RC = 9, E_RRD = 2;
    localparam int E_RFC = 10, E_MRD = 2, E_RTP = 2, E_WTP = 5, E_REFI = 1040;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready;
    logic [2:0]  req_op = '0;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic        dram_cke, dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n;
    logic [1:0]  dram_ba;
    logic [12:0] dram_a;

    ddrc_cmd_sched dut_i (.*);

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---- pin monitor with its own bank model ----
    int          cyc, t_act_any, t_ref, t_mrs, n_ref, first_ref, last_rw_t;
    int          t_act[4], t_pre[4], t_rd[4], t_wr[4];
    bit          m_open[4];
    logic [12:0] m_row[4];
    bit          prev_cke, exp_v, saw_pre_one, saw_pre_all;
    logic [2:0]  e_op;
    logic [1:0]  e_bank;
    logic [12:0] e_row;
    logic [9:0]  e_col;
    logic [3:0]  cmd;

    always @(negedge clk) begin
        cmd = {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n};
        if (!rst_n) begin
            cyc = 0; t_act_any = -1000; t_ref = -1000; t_mrs = -1000;
            n_ref = 0; first_ref = -1; prev_cke = 1'b1; exp_v = 1'b0;
            for (int b = 0; b < 4; b++) begin
                t_act[b] = -1000; t_pre[b] = -1000; t_rd[b] = -1000; t_wr[b] = -1000;
                m_open[b] = 1'b0; m_row[b] = '0;
            end
        end else begin
            cyc++;
            if (exp_v) begin
                exp_v = 1'b0;
                case (e_op)
                    3'd0, 3'd1: begin
                        chk(cmd == ((e_op == 3'd0) ? C_RD : C_WR), "R3 cmd", cmd, (e_op == 3'd0) ? C_RD : C_WR);
                        chk(dram_ba == e_bank && dram_a[9:0] == e_col, "R3 bank/col", {dram_ba, dram_a[9:0]}, {e_bank, e_col});
                        chk(m_open[e_bank] && m_row[e_bank] == e_row, "R3 row", m_row[e_bank], e_row);
                    end
                    3'd2: chk(cmd == C_REF, "R7 user refresh", cmd, C_REF);
                    3'd3: chk(cmd == C_MRS && dram_a == e_row && dram_ba == e_bank,
                              "R2 mode load", {cmd, dram_ba, dram_a}, {C_MRS, e_bank, e_row});
                    3'd4: chk(!dram_cke, "R10 cke low", dram_cke, 0);
                    default: chk(cmd == C_NOP && dram_cke, "R12 unused op", {dram_cke, cmd}, {1'b1, C_NOP});
                endcase
            end
            if (!dram_cke || !prev_cke) chk(cmd == C_NOP, "R10 nop around power-down", cmd, C_NOP);
            if (cmd != C_NOP) begin
                chk(cyc - t_ref >= E_RFC, "R8 refresh gap", cyc - t_ref, E_RFC);
                chk(cyc - t_mrs >= E_MRD, "R8 mode gap", cyc - t_mrs, E_MRD);
            end
            case (cmd)
                C_ACT: begin
                    chk(!m_open[dram_ba], "R6 activate closed bank", m_open[dram_ba], 0);
                    chk(cyc - t_pre[dram_ba] >= E_RP, "R6 tRP", cyc - t_pre[dram_ba], E_RP);
                    chk(cyc - t_act[dram_ba] >= E_RC, "R6 tRC", cyc - t_act[dram_ba], E_RC);
                    chk(cyc - t_act_any >= E_RRD, "R6 tRRD", cyc - t_act_any, E_RRD);
                    m_open[dram_ba] = 1'b1; m_row[dram_ba] = dram_a;
                    t_act[dram_ba] = cyc; t_act_any = cyc;
                end
                C_RD, C_WR: begin
                    chk(m_open[dram_ba], "R3 column to open bank", m_open[dram_ba], 1);
                    chk(cyc - t_act[dram_ba] >= E_RCD, "R4 tRCD", cyc - t_act[dram_ba], E_RCD);
                    chk(!dram_a[10], "R2 A10 low", dram_a[10], 0);
                    if (cmd == C_RD) t_rd[dram_ba] = cyc; else t_wr[dram_ba] = cyc;
                    last_rw_t = cyc;
                end
                C_PRE: begin
                    if (dram_a[10]) saw_pre_all = 1'b1;
                    else if (dram_ba == 2'd2) saw_pre_one = 1'b1;
                    for (int b = 0; b < 4; b++) begin
                        if (dram_a[10] || dram_ba == b[1:0]) begin
                            if (m_open[b]) begin
                                chk(cyc - t_act[b] >= E_RAS, "R5 tRAS", cyc - t_act[b], E_RAS);
                                chk(cyc - t_rd[b] >= E_RTP, "R5 read to precharge", cyc - t_rd[b], E_RTP);
                                chk(cyc - t_wr[b] >= E_WTP, "R5 write recovery", cyc - t_wr[b], E_WTP);
                            end
                            m_open[b] = 1'b0; t_pre[b] = cyc;
                        end
                    end
                end
                C_REF, C_MRS: begin
                    for (int b = 0; b < 4; b++) begin
                        chk(!m_open[b], "R7 all banks closed", m_open[b], 0);
                        chk(cyc - t_pre[b] >= E_RP, "R7 tRP before idle command", cyc - t_pre[b], E_RP);
                    end
                    if (cmd == C_REF) begin
                        t_ref = cyc; n_ref++;
                        if (first_ref < 0) first_ref = cyc;
                    end else t_mrs = cyc;
                end
                default: ;
            endcase
            if (!dram_cke && prev_cke)
                for (int b = 0; b < 4; b++) chk(!m_open[b], "R7 power-down idle", m_open[b], 0);
            if (req_valid && req_ready) begin
                exp_v = 1'b1; e_op = req_op; e_bank = req_bank; e_row = req_row; e_col = req_col;
            end
            prev_cke = dram_cke;
        end
    end

    task automatic send(input logic [2:0] op, input logic [1:0] b,
                        input logic [12:0] r, input logic [9:0] c);
        @(posedge clk); #1;
        req_valid = 1'b1; req_op = op; req_bank = b; req_row = r; req_col = c;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dram_cke && {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n} == C_NOP, "R1 in reset",
            {dram_cke, dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n}, {1'b1, C_NOP});
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(dram_cke && {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n} == C_NOP && !req_ready,
            "R1 after reset", {req_ready, dram_cke, dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n},
            {1'b0, 1'b1, C_NOP});

        // R9: first owed refresh on an idle device
        idle(E_REFI + 20);
        chk(first_ref >= E_REFI - 2 && first_ref <= E_REFI + 4, "R9 first refresh time", first_ref, E_REFI + 1);

        // R4: read to a closed bank, exact activate-to-read gap
        send(3'd0, 2'd2, 13'd5, 10'd9);
        idle(2);
        chk(last_rw_t - t_act[2] == E_RCD, "R4 exact gap", last_rw_t - t_act[2], E_RCD);

        // R11: row conflict on bank 2
        saw_pre_one = 1'b0;
        send(3'd0, 2'd2, 13'd6, 10'd4);
        chk(saw_pre_one, "R11 single-bank precharge", saw_pre_one, 1);
        chk(m_row[2] == 13'd6, "R11 new row opened", m_row[2], 6);

        // R7: mode load with bank 2 open forces a precharge-all
        saw_pre_all = 1'b0;
        send(3'd3, 2'd1, 13'h0123, 10'd0);
        chk(saw_pre_all, "R7 precharge-all before mode load", saw_pre_all, 1);

        // R10: power-down and wake-up
        send(3'd4, 2'd0, 13'd0, 10'd0);
        idle(20);
        @(negedge clk);
        chk(!dram_cke, "R10 stays in power-down", dram_cke, 0);
        send(3'd0, 2'd0, 13'd1, 10'd1);
        chk(dram_cke, "R10 woken by request", dram_cke, 1);

        // R12: unused op
        send(3'd6, 2'd3, 13'd0, 10'd0);

        // R5: write then conflicting read on bank 3
        send(3'd1, 2'd3, 13'd1, 10'd0);
        send(3'd0, 2'd3, 13'd2, 10'd7);

        // mixed random traffic
        void'($urandom(32'd2024));
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic [2:0] op;
            r = $urandom % 20;
            if (r < 8)        op = 3'd0;
            else if (r < 16)  op = 3'd1;
            else if (r == 16) op = 3'd2;
            else if (r == 17) op = 3'd3;
            else if (r == 18) op = 3'd4;
            else              op = 3'(5 + $urandom % 3);
            send(op, 2'($urandom % 4), 13'($urandom % 3), 10'($urandom % 1024));
            idle($urandom % 3);
        end
        idle(20);
        chk(n_ref >= cyc / E_REFI - 8, "R9 refresh rate", n_ref, cyc / E_REFI - 8);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5 * 190000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule